// File: doc/BRIEF.md
# Vector Configuration and Fixed-Point Control Register Unit

This block holds the configuration state that a vector execution pipeline consults on every instruction: the active element type word, the active vector length, the restart element index, the fixed-point rounding mode and the saturation flag. It executes configuration requests by decoding a requested type word, deriving the largest vector length that type allows for the implemented register width, and committing the new length and type together. It also serves the control-register read and write path with a one-cycle registered read, and it tracks the two-bit vector-state status field that decides whether vector work may run at all.

The length and type registers are read-only to the register path. Only a configuration request or a fault-on-first-element length override can change them. The combined fixed-point view is an alias of the rounding-mode and saturation fields, so a write through either name is seen through the other.

Top module: `vcfg_csr_unit`

## Requirements
- R1: While `rst` is high, at the next clock edge `vl_o`=0, `vtype_o` has only bit XLEN-1 set, and `vstart_o`, `vxrm_o` and `vxsat_o` are 0. The status becomes Initial (1), and `vec_allowed` is 1. The status codes are Off=0, Initial=1, Clean=2, Dirty=3.
- R2: A `cfg_req` with a legal type word sets `vtype_o` to that word's bits [7:0], zero-extended, and sets `vl_o` to min(`cfg_avl`, VLMAX) in the next cycle. The type word fields are vlmul=[2:0], vsew=[5:3], tail flag=[6] and mask flag=[7]. SEW is 8<<vsew. vlmul 0..3 gives LMUL 1,2,4,8, and VLMAX = LMUL*VLEN/SEW.
- R3: vlmul 5, 6 and 7 give fractional LMUL 1/8, 1/4 and 1/2. A type word is legal only if SEW<=ELEN and SEW<=LMUL*ELEN.
- R4: A type word is illegal if any of the following holds: vlmul is 4, vsew>3, any bit from 8 up to XLEN-1 is set, or the R3 limit fails. An illegal request sets `vtype_o` to only bit XLEN-1 and sets `vl_o` to 0.
- R5: `ffo_we` replaces `vl_o` with `ffo_vl` only when `ffo_vl` is below the current `vl_o`. A larger value is ignored. A simultaneous `cfg_req` takes priority.
- R6: The register addresses are 0x008 restart index, 0x009 saturation, 0x00A rounding, 0x00F combined, 0xC20 length, 0xC21 type and 0xC22 register bytes. A write to 0xC20, 0xC21 or 0xC22 changes nothing and raises `csr_err`. Reading 0xC22 returns VLEN/8.
- R7: The rounding-mode write keeps bits [1:0], and the saturation write keeps bit 0. The combined register reads {rounding, saturation} in bits [2:0]. A write to it sets rounding from bits [2:1] and saturation from bit 0. Writing one field leaves the other intact.
- R8: A register write sets the restart index from the low `$clog2(VLEN)` bits. `insn_retire` clears it in the next cycle, and retire wins over a write in the same cycle.
- R9: An accepted configuration request, an accepted length override or an accepted register write sets the status to Dirty (3).
- R10: While the status is Off, `vec_allowed` is 0. Configuration requests, overrides and register writes are ignored, and every register access raises `csr_err` and reads 0.
- R11: Read data and `csr_err` appear one cycle after `csr_rd` or `csr_we`. An unknown address reads 0 with `csr_err`=1.
- R12: `vs_set_we` loads `vs_set_val` into the status, with priority over the Dirty marking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_req | input | 1 | Configuration request strobe |
| cfg_avl | input | XLEN | Requested application vector length |
| cfg_vtype | input | XLEN | Requested type word |
| ffo_we | input | 1 | Fault-on-first length override strobe |
| ffo_vl | input | XLEN | Override length |
| csr_rd | input | 1 | Register read strobe |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 12 | Register address |
| csr_wdata | input | XLEN | Register write data |
| csr_rdata | output | XLEN | Registered read data |
| csr_err | output | 1 | Registered access error |
| insn_retire | input | 1 | Vector instruction retire strobe |
| vs_set_we | input | 1 | Status field load strobe |
| vs_set_val | input | 2 | Status field load value |
| vs_o | output | 2 | Vector-state status |
| vec_allowed | output | 1 | Vector instructions permitted |
| vtype_o | output | XLEN | Active type word |
| vl_o | output | XLEN | Active vector length |
| vstart_o | output | $clog2(VLEN) | Restart element index |
| vxrm_o | output | 2 | Fixed-point rounding mode |
| vxsat_o | output | 1 | Saturation flag |

## Verification
The assertions check several properties on every cycle. An illegal type always goes with a zero length and no other type bits. The length never exceeds VLEN. The length and type hold unless a configuration request or an override occurs, and an override never raises the length. A retire always leaves the index at zero. A configuration request always leads to Dirty, and the Off state freezes the configuration. The exact VLMAX for each LMUL and SEW pair, the fractional-LMUL legality limits, the aliasing of the combined fixed-point view, the read-only error path and the read timing are shown only by the bench's scenarios, which compare the outputs against independently computed values.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;
  typedef enum logic [1:0] {
    VS_OFF   = 2'd0,
    VS_INIT  = 2'd1,
    VS_CLEAN = 2'd2,
    VS_DIRTY = 2'd3
  } vs_e;

  localparam logic [11:0] A_VSTART = 12'h008;
  localparam logic [11:0] A_VXSAT  = 12'h009;
  localparam logic [11:0] A_VXRM   = 12'h00A;
  localparam logic [11:0] A_VCSR   = 12'h00F;
  localparam logic [11:0] A_VL     = 12'hC20;
  localparam logic [11:0] A_VTYPE  = 12'hC21;
  localparam logic [11:0] A_VLENB  = 12'hC22;

  typedef struct packed {
    logic       mask_agn;
    logic       tail_agn;
    logic [2:0] sew_code;
    logic [2:0] lmul_code;
  } vtype_fields_t;
endpackage

// File: rtl/vcfg_vtype_dec.sv
module vcfg_vtype_dec #(
  parameter int XLEN = 32,
  parameter int VLEN = 128,
  parameter int ELEN = 32
) (
  input  logic [XLEN-1:0] req_vtype,
  input  logic [XLEN-1:0] avl,
  output logic            legal,
  output logic [XLEN-1:0] new_vtype,
  output logic [XLEN-1:0] new_vl
);
  import vcfg_pkg::*;
  localparam int LG_VLEN = $clog2(VLEN);
  localparam int LG_ELEN = $clog2(ELEN);

  vtype_fields_t   fld;
  logic            upper_clear;
  int              lg_sew;
  int              lg_lmul;
  int              lg_vmax;
  logic [XLEN-1:0] vlmax;

  always_comb begin
    fld         = req_vtype[7:0];
    upper_clear = (req_vtype[XLEN-1:8] == '0);
    lg_sew      = 3 + int'(fld.sew_code);
    lg_lmul     = fld.lmul_code[2] ? int'(fld.lmul_code) - 8 : int'(fld.lmul_code);
    legal       = upper_clear && (fld.sew_code <= 3'd3) && (fld.lmul_code != 3'd4) &&
                  (lg_sew <= LG_ELEN) && (lg_sew <= LG_ELEN + lg_lmul);
    lg_vmax     = LG_VLEN + lg_lmul - lg_sew;
    vlmax       = '0;
    if (legal) vlmax = {{(XLEN-1){1'b0}}, 1'b1} << lg_vmax;
    if (legal) begin
      new_vtype = {{(XLEN-8){1'b0}}, req_vtype[7:0]};
      new_vl    = (avl < vlmax) ? avl : vlmax;
    end else begin
      new_vtype = {1'b1, {(XLEN-1){1'b0}}};
      new_vl    = '0;
    end
  end
endmodule

// File: rtl/vcfg_vs_track.sv
module vcfg_vs_track (
  input  logic       clk,
  input  logic       rst,
  input  logic       set_we,
  input  logic [1:0] set_val,
  input  logic       mark_dirty,
  output logic [1:0] vs_q,
  output logic       allowed_q
);
  import vcfg_pkg::*;
  logic [1:0] vs_n;

  always_comb begin
    vs_n = vs_q;
    if (set_we)          vs_n = set_val;
    else if (mark_dirty) vs_n = VS_DIRTY;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vs_q      <= VS_INIT;
      allowed_q <= 1'b1;
    end else begin
      vs_q      <= vs_n;
      allowed_q <= (vs_n != VS_OFF);
    end
  end
endmodule

// File: rtl/vcfg_csr_unit.sv
module vcfg_csr_unit #(
  parameter int XLEN     = 32,
  parameter int VLEN     = 128,
  parameter int ELEN     = 32,
  parameter int VSTART_W = $clog2(VLEN)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_req,
  input  logic [XLEN-1:0]     cfg_avl,
  input  logic [XLEN-1:0]     cfg_vtype,
  input  logic                ffo_we,
  input  logic [XLEN-1:0]     ffo_vl,
  input  logic                csr_rd,
  input  logic                csr_we,
  input  logic [11:0]         csr_addr,
  input  logic [XLEN-1:0]     csr_wdata,
  output logic [XLEN-1:0]     csr_rdata,
  output logic                csr_err,
  input  logic                insn_retire,
  input  logic                vs_set_we,
  input  logic [1:0]          vs_set_val,
  output logic [1:0]          vs_o,
  output logic                vec_allowed,
  output logic [XLEN-1:0]     vtype_o,
  output logic [XLEN-1:0]     vl_o,
  output logic [VSTART_W-1:0] vstart_o,
  output logic [1:0]          vxrm_o,
  output logic                vxsat_o
);
  import vcfg_pkg::*;
  localparam logic [XLEN-1:0] VLENB_VAL = XLEN'(VLEN / 8);
  localparam logic [XLEN-1:0] VILL_ONLY = {1'b1, {(XLEN-1){1'b0}}};

  logic            dec_legal;
  logic [XLEN-1:0] dec_vtype;
  logic [XLEN-1:0] dec_vl;
  logic            addr_known;
  logic            addr_ro;
  logic            cfg_fire;
  logic            ffo_fire;
  logic            wr_fire;
  logic [XLEN-1:0] rd_mux;

  vcfg_vtype_dec #(.XLEN(XLEN), .VLEN(VLEN), .ELEN(ELEN)) i_dec (
    .req_vtype (cfg_vtype),
    .avl       (cfg_avl),
    .legal     (dec_legal),
    .new_vtype (dec_vtype),
    .new_vl    (dec_vl)
  );

  always_comb begin
    addr_known = 1'b1;
    addr_ro    = 1'b0;
    rd_mux     = '0;
    case (csr_addr)
      A_VSTART: rd_mux = {{(XLEN-VSTART_W){1'b0}}, vstart_o};
      A_VXSAT:  rd_mux = {{(XLEN-1){1'b0}}, vxsat_o};
      A_VXRM:   rd_mux = {{(XLEN-2){1'b0}}, vxrm_o};
      A_VCSR:   rd_mux = {{(XLEN-3){1'b0}}, vxrm_o, vxsat_o};
      A_VL:     begin rd_mux = vl_o;      addr_ro = 1'b1; end
      A_VTYPE:  begin rd_mux = vtype_o;   addr_ro = 1'b1; end
      A_VLENB:  begin rd_mux = VLENB_VAL; addr_ro = 1'b1; end
      default:  addr_known = 1'b0;
    endcase
  end

  assign cfg_fire = cfg_req && vec_allowed;
  assign ffo_fire = ffo_we && vec_allowed && !cfg_req && (ffo_vl < vl_o);
  assign wr_fire  = csr_we && vec_allowed && addr_known && !addr_ro;

  vcfg_vs_track i_vs (
    .clk        (clk),
    .rst        (rst),
    .set_we     (vs_set_we),
    .set_val    (vs_set_val),
    .mark_dirty (cfg_fire || ffo_fire || wr_fire),
    .vs_q       (vs_o),
    .allowed_q  (vec_allowed)
  );

  // Length and type: configuration first, then override.
  always_ff @(posedge clk) begin
    if (rst) begin
      vtype_o <= VILL_ONLY;
      vl_o    <= '0;
    end else if (cfg_fire) begin
      vtype_o <= dec_vtype;
      vl_o    <= dec_vl;
    end else if (ffo_fire) begin
      vl_o    <= ffo_vl;
    end
  end

  // Restart index and fixed-point fields.
  always_ff @(posedge clk) begin
    if (rst) begin
      vstart_o <= '0;
      vxrm_o   <= 2'd0;
      vxsat_o  <= 1'b0;
    end else begin
      if (insn_retire)                          vstart_o <= '0;
      else if (wr_fire && csr_addr == A_VSTART) vstart_o <= csr_wdata[VSTART_W-1:0];
      if (wr_fire && csr_addr == A_VXRM)        vxrm_o   <= csr_wdata[1:0];
      else if (wr_fire && csr_addr == A_VCSR)   vxrm_o   <= csr_wdata[2:1];
      if (wr_fire && (csr_addr == A_VXSAT || csr_addr == A_VCSR))
        vxsat_o <= csr_wdata[0];
    end
  end

  // Registered read path.
  always_ff @(posedge clk) begin
    if (rst) begin
      csr_rdata <= '0;
      csr_err   <= 1'b0;
    end else begin
      csr_rdata <= (csr_rd && vec_allowed && addr_known) ? rd_mux : '0;
      csr_err   <= (csr_rd || csr_we) &&
                   (!vec_allowed || !addr_known || (csr_we && addr_ro));
    end
  end
endmodule

// File: rtl/vcfg_csr_unit_chk.sv
module vcfg_csr_unit_chk #(
  parameter int XLEN     = 32,
  parameter int VLEN     = 128,
  parameter int VSTART_W = $clog2(VLEN)
) (
  input logic                clk,
  input logic                rst,
  input logic                cfg_req,
  input logic                ffo_we,
  input logic                insn_retire,
  input logic                vs_set_we,
  input logic [1:0]          vs_o,
  input logic                vec_allowed,
  input logic [XLEN-1:0]     vtype_o,
  input logic [XLEN-1:0]     vl_o,
  input logic [VSTART_W-1:0] vstart_o,
  input logic [1:0]          vxrm_o,
  input logic                vxsat_o
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (vl_o == '0 && vtype_o == {1'b1, {(XLEN-1){1'b0}}} && vstart_o == '0 &&
             vxrm_o == 2'd0 && !vxsat_o && vs_o == 2'd1 && vec_allowed));

  a_r2_vl_bounded: assert property (@(posedge clk) disable iff (rst)
    vl_o <= XLEN'(VLEN));

  a_r4_vill_clean: assert property (@(posedge clk) disable iff (rst)
    vtype_o[XLEN-1] |-> (vl_o == '0 && vtype_o[XLEN-2:0] == '0));

  a_r5_ffo_no_grow: assert property (@(posedge clk) disable iff (rst)
    (ffo_we && !cfg_req) |=> vl_o <= $past(vl_o));

  a_r6_readonly_cfg: assert property (@(posedge clk) disable iff (rst)
    (!cfg_req && !ffo_we) |=> ($stable(vl_o) && $stable(vtype_o)));

  a_r8_retire_clears: assert property (@(posedge clk) disable iff (rst)
    insn_retire |=> vstart_o == '0);

  a_r9_cfg_dirty: assert property (@(posedge clk) disable iff (rst)
    (cfg_req && vec_allowed && !vs_set_we) |=> vs_o == 2'd3);

  a_r10_off_gate: assert property (@(posedge clk) disable iff (rst)
    (vs_o == 2'd0) |-> !vec_allowed);

  a_r10_off_frozen: assert property (@(posedge clk) disable iff (rst)
    (!vec_allowed && !vs_set_we) |=>
      ($stable(vl_o) && $stable(vtype_o) && $stable(vxrm_o) && $stable(vxsat_o)));
endmodule

bind vcfg_csr_unit vcfg_csr_unit_chk #(.XLEN(XLEN), .VLEN(VLEN), .VSTART_W(VSTART_W)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_req     (cfg_req),
  .ffo_we      (ffo_we),
  .insn_retire (insn_retire),
  .vs_set_we   (vs_set_we),
  .vs_o        (vs_o),
  .vec_allowed (vec_allowed),
  .vtype_o     (vtype_o),
  .vl_o        (vl_o),
  .vstart_o    (vstart_o),
  .vxrm_o      (vxrm_o),
  .vxsat_o     (vxsat_o)
);

// File: tb/test_vcfg_csr_unit.sv
module test_vcfg_csr_unit;
  localparam int XLEN = 32;
  localparam int VLEN = 128;
  localparam int VSW  = $clog2(VLEN);
  localparam int NT   = 14;

  // Table: requested type, AVL, expected length, expected type. R2/R3 legal rows, R4 illegal rows.
  localparam logic [31:0] T_VT [NT] = '{32'h10, 32'h13, 32'h03, 32'h0F, 32'h06, 32'hD1, 32'h08,
                                        32'h18, 32'h04, 32'h0E, 32'h100, 32'h05, 32'h8000_0000, 32'h20};
  localparam logic [31:0] T_AVL[NT] = '{10, 100, 200, 3, 9, 8, 0, 5, 5, 5, 5, 5, 5, 5};
  localparam logic [31:0] T_VL [NT] = '{4, 32, 128, 3, 4, 8, 0, 0, 0, 0, 0, 0, 0, 0};
  localparam logic [31:0] T_EVT[NT] = '{32'h10, 32'h13, 32'h03, 32'h0F, 32'h06, 32'hD1, 32'h08,
                                        32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 32'h8000_0000,
                                        32'h8000_0000, 32'h8000_0000, 32'h8000_0000};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_req = 1'b0, ffo_we = 1'b0, csr_rd = 1'b0, csr_we = 1'b0;
  logic insn_retire = 1'b0, vs_set_we = 1'b0;
  logic [XLEN-1:0] cfg_avl = '0, cfg_vtype = '0, ffo_vl = '0, csr_wdata = '0;
  logic [11:0] csr_addr = '0;
  logic [1:0] vs_set_val = '0;
  logic [XLEN-1:0] csr_rdata, vtype_o, vl_o;
  logic csr_err, vec_allowed, vxsat_o;
  logic [1:0] vs_o, vxrm_o;
  logic [VSW-1:0] vstart_o;

  int checks = 0;
  int errors = 0;
  logic [XLEN-1:0] rd_v;
  logic rd_e;

  always #10 clk = ~clk;

  vcfg_csr_unit #(.XLEN(XLEN), .VLEN(VLEN), .ELEN(32)) i_vcfg_csr_unit (
    .clk(clk), .rst(rst), .cfg_req(cfg_req), .cfg_avl(cfg_avl), .cfg_vtype(cfg_vtype),
    .ffo_we(ffo_we), .ffo_vl(ffo_vl), .csr_rd(csr_rd), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .csr_err(csr_err), .insn_retire(insn_retire),
    .vs_set_we(vs_set_we), .vs_set_val(vs_set_val), .vs_o(vs_o), .vec_allowed(vec_allowed),
    .vtype_o(vtype_o), .vl_o(vl_o), .vstart_o(vstart_o), .vxrm_o(vxrm_o), .vxsat_o(vxsat_o));

  task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic vsetvl(input logic [XLEN-1:0] vt, input logic [XLEN-1:0] avl);
    @(negedge clk); cfg_req = 1'b1; cfg_vtype = vt; cfg_avl = avl;
    @(negedge clk); cfg_req = 1'b0;
  endtask

  task automatic csr_wr(input logic [11:0] a, input logic [XLEN-1:0] d);
    @(negedge clk); csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk); csr_we = 1'b0; rd_e = csr_err;
  endtask

  task automatic csr_rdt(input logic [11:0] a);
    @(negedge clk); csr_rd = 1'b1; csr_addr = a;
    @(negedge clk); csr_rd = 1'b0; rd_v = csr_rdata; rd_e = csr_err;
  endtask

  task automatic vs_set(input logic [1:0] v);
    @(negedge clk); vs_set_we = 1'b1; vs_set_val = v;
    @(negedge clk); vs_set_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 vl", vl_o, 0);
    chk("R1 vtype", vtype_o, 32'h8000_0000);
    chk("R1 fixed-point", {vstart_o, vxrm_o, vxsat_o}, 0);
    chk("R1 status", {vs_o, vec_allowed}, {2'd1, 1'b1});

    for (int i = 0; i < NT; i++) begin
      vsetvl(T_VT[i], T_AVL[i]);
      chk(T_EVT[i][31] ? "R4 illegal vl" : "R2/R3 legal vl", vl_o, T_VL[i]);
      chk(T_EVT[i][31] ? "R4 illegal vtype" : "R2/R3 legal vtype", vtype_o, T_EVT[i]);
    end
    chk("R9 dirty after config", vs_o, 2'd3);

    // R6 read-only length/type
    vsetvl(32'h10, 10);
    csr_wr(12'hC20, 5);   chk("R6 vl write err", rd_e, 1); chk("R6 vl kept", vl_o, 4);
    csr_wr(12'hC21, 0);   chk("R6 vtype write err", rd_e, 1); chk("R6 vtype kept", vtype_o, 32'h10);
    csr_rdt(12'hC20);     chk("R6 vl read", rd_v, 4); chk("R11 err clear", rd_e, 0);
    csr_rdt(12'hC21);     chk("R6 vtype read", rd_v, 32'h10);
    csr_rdt(12'hC22);     chk("R6 vlenb read", rd_v, VLEN / 8);
    csr_rdt(12'h123);     chk("R11 unknown data", rd_v, 0); chk("R11 unknown err", rd_e, 1);

    // R7 aliasing
    csr_wr(12'h00A, 32'hFF); chk("R7 vxrm", vxrm_o, 3);
    csr_rdt(12'h00F);        chk("R7 vcsr view", rd_v, 6);
    csr_wr(12'h009, 32'hFE); chk("R7 vxsat bit0 only", vxsat_o, 0);
    csr_wr(12'h009, 32'h03); chk("R7 vxsat set", vxsat_o, 1);
    csr_rdt(12'h00F);        chk("R7 vcsr both", rd_v, 7);
    csr_wr(12'h00F, 32'h02); chk("R7 vcsr write", {vxrm_o, vxsat_o}, 3'b010);
    csr_rdt(12'h00A);        chk("R7 vxrm readback", rd_v, 1);
    csr_rdt(12'h009);        chk("R7 vxsat readback", rd_v, 0);

    // R8 restart index
    csr_wr(12'h008, 32'h1A5); chk("R8 vstart write", vstart_o, 7'h25);
    @(negedge clk); insn_retire = 1'b1;
    @(negedge clk); insn_retire = 1'b0; chk("R8 retire clear", vstart_o, 0);
    csr_wr(12'h008, 9);
    @(negedge clk); insn_retire = 1'b1; csr_we = 1'b1; csr_addr = 12'h008; csr_wdata = 33;
    @(negedge clk); insn_retire = 1'b0; csr_we = 1'b0; chk("R8 retire wins", vstart_o, 0);

    // R5 override
    @(negedge clk); ffo_we = 1'b1; ffo_vl = 2;
    @(negedge clk); ffo_we = 1'b0; chk("R5 shrink", vl_o, 2);
    @(negedge clk); ffo_we = 1'b1; ffo_vl = 3;
    @(negedge clk); ffo_we = 1'b0; chk("R5 no grow", vl_o, 2);
    @(negedge clk); ffo_we = 1'b1; ffo_vl = 1; cfg_req = 1'b1; cfg_vtype = 32'h13; cfg_avl = 20;
    @(negedge clk); ffo_we = 1'b0; cfg_req = 1'b0; chk("R5 config priority", vl_o, 20);

    // R12 / R9 status handling
    vs_set(2'd2); chk("R12 load clean", vs_o, 2);
    csr_wr(12'h00A, 0); chk("R9 write dirty", vs_o, 3);
    @(negedge clk); vs_set_we = 1'b1; vs_set_val = 2'd2; cfg_req = 1'b1; cfg_vtype = 32'h10; cfg_avl = 1;
    @(negedge clk); vs_set_we = 1'b0; cfg_req = 1'b0; chk("R12 load beats dirty", vs_o, 2);

    // R10 Off gating
    vs_set(2'd0); chk("R10 not allowed", vec_allowed, 0);
    vsetvl(32'h13, 100); chk("R10 config ignored", vl_o, 1);
    csr_wr(12'h00A, 2);  chk("R10 write err", rd_e, 1);
    csr_rdt(12'h00A);    chk("R10 read zero", rd_v, 0); chk("R10 read err", rd_e, 1);
    vs_set(2'd1);        chk("R10 allowed again", vec_allowed, 1);
    csr_rdt(12'h00A);    chk("R10 vxrm untouched", rd_v, 0);

    // R1 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 re-reset vtype", vtype_o, 32'h8000_0000);
    chk("R1 re-reset vl", vl_o, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule